// File: doc/BRIEF.md
# Potentiometer Wiper Position Register with Start-Up Recall

This block keeps the 7-bit tap code that selects the wiper position of a digitally controlled potentiometer. Code 0x00 puts the wiper next to the low end of the resistor string and code 0x7F next to the high end, and the position moves monotonically in between. Alongside the live code it keeps a copy of the stored start-up value. It also holds a one-bit access mode that decides whether writes reach the non-volatile store.

After reset the tap sits at mid-scale (0x40). A programmable number of cycles later the block asks the non-volatile store for the start-up byte. When the byte arrives, the block loads it into the tap and raises `recall_done`. Until then it reports `busy` and ignores the serial-interface strobes.

Once the recall is complete, the serial interface decodes transfers and reaches the block through strobes that carry an 11-bit address and a data byte. The all-ones address is the wiper/start-up byte and the address just below it is the mode byte. A write to the wiper byte moves the tap as soon as its last data bit has been clocked in. If the mode bit is clear, the same byte is also sent on to the non-volatile store.

Top module: `wiper_recall_ctrl`

## Requirements
- R1: While `rst` is high, the block holds `tap_code` at 0x40, `recall_done` low, `busy` high, and `nv_rd_req`, `nv_wr_req` and `bus_rd_valid` low. The mode bit is cleared.
- R2: After `rst` falls, `nv_rd_req` pulses high for exactly one cycle. It is seen high after RECALL_WAIT clock edges. When `nv_rd_valid` is high, `tap_code` takes `nv_rd_data[6:0]` on that clock edge, and `recall_done` rises and stays high from then on.
- R3: While `busy` is high, the block ignores `bus_lsb_stb`, `bus_wr_stb` and `bus_rd_req`: the tap holds, and no read data or store write comes out.
- R4: `bus_lsb_stb` with address 0x7FF loads `bus_wdata[6:0]` into `tap_code` on the next edge, whatever the mode bit is. Bit 7 of the data is dropped.
- R5: `bus_wr_stb` with address 0x7FE sets the mode bit to `bus_wdata[7]` only if `bus_wdata[6:0]` is zero. Any other value leaves the mode bit unchanged.
- R6: `bus_wr_stb` with address 0x7FF while the mode bit is 0 produces a one-cycle `nv_wr_req` on the next cycle, with `nv_wr_data = {0, bus_wdata[6:0]}`, and updates the held start-up copy. While the mode bit is 1 it produces no store write.
- R7: `bus_rd_req` with address 0x7FF gives `bus_rd_valid` one cycle later with `bus_rdata = {0, tap_code}` when the mode bit is 1, and `{0, start-up copy}` when it is 0.
- R8: `bus_rd_req` with address 0x7FE returns `{mode bit, 0000000}` one cycle later.
- R9: Strobes at any other address, including the reserved 0x7FC and 0x7FD, change neither the tap, the mode bit nor the store. Reads there leave `bus_rd_valid` low.
- R10: A mode-byte write immediately followed by a wiper-byte write uses the newly written mode bit for the second byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 11 | Target address of the current strobe |
| bus_wdata | input | 8 | Received data byte |
| bus_wr_stb | input | 1 | Data byte accepted for a write |
| bus_lsb_stb | input | 1 | Last data bit of a write byte clocked in |
| bus_rd_req | input | 1 | Read request at `bus_addr` |
| bus_rdata | output | 8 | Read data |
| bus_rd_valid | output | 1 | Read data valid; the address is owned by the block |
| busy | output | 1 | Start-up recall not finished |
| recall_done | output | 1 | Start-up value has been loaded |
| nv_rd_req | output | 1 | One-cycle request for the stored start-up byte |
| nv_rd_data | input | 8 | Start-up byte from the store |
| nv_rd_valid | input | 1 | `nv_rd_data` valid |
| nv_wr_req | output | 1 | One-cycle request to write the start-up byte |
| nv_wr_data | output | 8 | Byte to store |
| tap_code | output | 7 | Wiper position code |

## Verification
The assertions assume that the serial interface raises at most one of the three bus strobes in a cycle. They also assume that the store answers a recall request only once, and only after that request. The stimulus keeps within both: every randomly chosen operation drives one strobe for a single cycle and then idles for a cycle. The store model answers the single recall request two cycles after it sees it. Addresses are drawn mostly from the four top locations so that the mode-dependent paths are exercised often, with occasional random addresses elsewhere.

// File: rtl/wpr_pkg.sv
package wpr_pkg;
  typedef enum logic [1:0] {
    RS_WAIT   = 2'd0,
    RS_ASK    = 2'd1,
    RS_LISTEN = 2'd2,
    RS_DONE   = 2'd3
  } recall_st_e;
endpackage

// File: rtl/wpr_addr_decode.sv
module wpr_addr_decode #(
  parameter int ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_wiper,
  output logic              hit_mode
);
  localparam logic [ADDR_W-1:0] WIPER_ADDR = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] MODE_ADDR  = WIPER_ADDR - 1'b1;

  always_comb begin
    hit_wiper = (addr == WIPER_ADDR);
    hit_mode  = (addr == MODE_ADDR);
  end
endmodule

// File: rtl/wpr_recall_seq.sv
module wpr_recall_seq
  import wpr_pkg::*;
#(
  parameter int RECALL_WAIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic nv_rd_valid,
  output logic nv_rd_req,
  output logic load_stb,
  output logic recall_done
);
  localparam int CW = $clog2(RECALL_WAIT + 1);
  localparam logic [CW-1:0] LAST = CW'(RECALL_WAIT - 1);

  recall_st_e    state;
  logic [CW-1:0] cnt;

  always_comb load_stb = nv_rd_valid && ((state == RS_ASK) || (state == RS_LISTEN));

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= RS_WAIT;
      cnt         <= '0;
      nv_rd_req   <= 1'b0;
      recall_done <= 1'b0;
    end else begin
      nv_rd_req <= 1'b0;
      case (state)
        RS_WAIT: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            state     <= RS_ASK;
            nv_rd_req <= 1'b1;
          end
        end
        RS_ASK, RS_LISTEN: begin
          if (nv_rd_valid) begin
            state       <= RS_DONE;
            recall_done <= 1'b1;
          end else begin
            state <= RS_LISTEN;
          end
        end
        default: state <= RS_DONE;
      endcase
    end
  end
endmodule

// File: rtl/wpr_reg_file.sv
module wpr_reg_file #(
  parameter int TAP_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              recall_load,
  input  logic [DATA_W-1:0] recall_data,
  input  logic              lsb_stb,
  input  logic              wr_stb,
  input  logic              rd_req,
  input  logic              hit_wiper,
  input  logic              hit_mode,
  input  logic [DATA_W-1:0] wdata,
  output logic [TAP_W-1:0]  tap,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rdata,
  output logic              nv_wr_req,
  output logic [DATA_W-1:0] nv_wr_data
);
  localparam int PAD = DATA_W - TAP_W;
  localparam logic [TAP_W-1:0] MID = TAP_W'(1) << (TAP_W - 1);

  logic [TAP_W-1:0] start_copy;
  logic             vol_only;
  logic             mode_ok;

  always_comb mode_ok = (wdata[DATA_W-2:0] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      tap        <= MID;
      start_copy <= MID;
      vol_only   <= 1'b0;
      rd_valid   <= 1'b0;
      rdata      <= '0;
      nv_wr_req  <= 1'b0;
      nv_wr_data <= '0;
    end else begin
      nv_wr_req <= 1'b0;
      rd_valid  <= 1'b0;
      if (recall_load) begin
        tap        <= recall_data[TAP_W-1:0];
        start_copy <= recall_data[TAP_W-1:0];
      end else if (en && lsb_stb && hit_wiper) begin
        tap <= wdata[TAP_W-1:0];
      end
      if (en && wr_stb && hit_mode && mode_ok)
        vol_only <= wdata[DATA_W-1];
      if (en && wr_stb && hit_wiper && !vol_only) begin
        start_copy <= wdata[TAP_W-1:0];
        nv_wr_req  <= 1'b1;
        nv_wr_data <= {{PAD{1'b0}}, wdata[TAP_W-1:0]};
      end
      if (en && rd_req) begin
        rd_valid <= hit_wiper || hit_mode;
        if (hit_wiper)
          rdata <= {{PAD{1'b0}}, (vol_only ? tap : start_copy)};
        else if (hit_mode)
          rdata <= {vol_only, {(DATA_W-1){1'b0}}};
        else
          rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/wiper_recall_ctrl.sv
module wiper_recall_ctrl #(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int TAP_W       = 7,
  parameter int RECALL_WAIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr_stb,
  input  logic              bus_lsb_stb,
  input  logic              bus_rd_req,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rd_valid,
  output logic              busy,
  output logic              recall_done,
  output logic              nv_rd_req,
  input  logic [DATA_W-1:0] nv_rd_data,
  input  logic              nv_rd_valid,
  output logic              nv_wr_req,
  output logic [DATA_W-1:0] nv_wr_data,
  output logic [TAP_W-1:0]  tap_code
);
  logic hit_wiper, hit_mode, load_stb;

  wpr_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr      (bus_addr),
    .hit_wiper (hit_wiper),
    .hit_mode  (hit_mode)
  );

  wpr_recall_seq #(.RECALL_WAIT(RECALL_WAIT)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .nv_rd_valid (nv_rd_valid),
    .nv_rd_req   (nv_rd_req),
    .load_stb    (load_stb),
    .recall_done (recall_done)
  );

  always_comb busy = !recall_done;

  wpr_reg_file #(.TAP_W(TAP_W), .DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .en          (recall_done),
    .recall_load (load_stb),
    .recall_data (nv_rd_data),
    .lsb_stb     (bus_lsb_stb),
    .wr_stb      (bus_wr_stb),
    .rd_req      (bus_rd_req),
    .hit_wiper   (hit_wiper),
    .hit_mode    (hit_mode),
    .wdata       (bus_wdata),
    .tap         (tap_code),
    .rd_valid    (bus_rd_valid),
    .rdata       (bus_rdata),
    .nv_wr_req   (nv_wr_req),
    .nv_wr_data  (nv_wr_data)
  );
endmodule

// File: rtl/wpr_checker.sv
module wpr_checker #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int TAP_W  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_lsb_stb,
  input logic              bus_rd_valid,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              busy,
  input logic              recall_done,
  input logic              nv_rd_req,
  input logic              nv_rd_valid,
  input logic              nv_wr_req,
  input logic [DATA_W-1:0] nv_wr_data,
  input logic [TAP_W-1:0]  tap_code
);
  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    recall_done |=> recall_done); // R2
  AST_RDREQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    nv_rd_req |=> !nv_rd_req); // R2
  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!nv_wr_req && !bus_rd_valid)); // R3
  AST_TAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!(bus_lsb_stb && bus_addr == TOP) && !nv_rd_valid) |=> $stable(tap_code)); // R4
  AST_WRREQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    nv_wr_req |=> !nv_wr_req); // R6
  AST_WRDATA_MSB: assert property (@(posedge clk) disable iff (rst)
    nv_wr_req |-> !nv_wr_data[DATA_W-1]); // R6
  AST_RD_MSB: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_valid && $past(bus_addr) == TOP) |-> !bus_rdata[DATA_W-1]); // R7
endmodule

bind wiper_recall_ctrl wpr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAP_W(TAP_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_addr     (bus_addr),
  .bus_lsb_stb  (bus_lsb_stb),
  .bus_rd_valid (bus_rd_valid),
  .bus_rdata    (bus_rdata),
  .busy         (busy),
  .recall_done  (recall_done),
  .nv_rd_req    (nv_rd_req),
  .nv_rd_valid  (nv_rd_valid),
  .nv_wr_req    (nv_wr_req),
  .nv_wr_data   (nv_wr_data),
  .tap_code     (tap_code)
);

// File: tb/wiper_recall_ctrl_test.sv
module wiper_recall_ctrl_test;
  localparam int W = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr_stb = 1'b0, bus_lsb_stb = 1'b0, bus_rd_req = 1'b0;
  logic [7:0]  bus_rdata;
  logic        bus_rd_valid, busy, recall_done, nv_rd_req, nv_wr_req;
  logic [7:0]  nv_rd_data = '0;
  logic        nv_rd_valid = 1'b0;
  logic [7:0]  nv_wr_data;
  logic [6:0]  tap_code;

  int n_chk = 0, n_bad = 0;
  logic [6:0] m_tap, m_copy;
  logic       m_mode;

  always #2 clk = ~clk;

  wiper_recall_ctrl #(.RECALL_WAIT(W)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr_stb(bus_wr_stb), .bus_lsb_stb(bus_lsb_stb), .bus_rd_req(bus_rd_req),
    .bus_rdata(bus_rdata), .bus_rd_valid(bus_rd_valid), .busy(busy),
    .recall_done(recall_done), .nv_rd_req(nv_rd_req), .nv_rd_data(nv_rd_data),
    .nv_rd_valid(nv_rd_valid), .nv_wr_req(nv_wr_req), .nv_wr_data(nv_wr_data),
    .tap_code(tap_code)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit owned(input logic [10:0] a);
    return (a == 11'h7FF) || (a == 11'h7FE);
  endfunction

  function automatic logic [7:0] exp_read(input logic [10:0] a);
    if (a == 11'h7FF) return {1'b0, (m_mode ? m_tap : m_copy)};
    if (a == 11'h7FE) return {m_mode, 7'b0};
    return 8'h00;
  endfunction

  // kind: 0 lsb strobe, 1 write strobe, 2 read request
  task automatic bus_op(input int kind, input logic [10:0] a, input logic [7:0] d, input string req);
    logic       e_nvw;
    logic [7:0] e_rd;
    logic       e_rdv;
    e_nvw = (kind == 1) && (a == 11'h7FF) && !m_mode;
    e_rdv = (kind == 2) && owned(a);
    e_rd  = exp_read(a);
    @(negedge clk);
    bus_addr = a; bus_wdata = d;
    bus_lsb_stb = (kind == 0); bus_wr_stb = (kind == 1); bus_rd_req = (kind == 2);
    @(negedge clk);
    bus_lsb_stb = 1'b0; bus_wr_stb = 1'b0; bus_rd_req = 1'b0;
    if (kind == 0 && a == 11'h7FF) m_tap = d[6:0];
    if (kind == 1 && a == 11'h7FE && d[6:0] == 7'd0) m_mode = d[7];
    if (e_nvw) m_copy = d[6:0];
    chk(req, "tap_code", int'(tap_code), int'(m_tap));
    chk(req, "nv_wr_req", int'(nv_wr_req), int'(e_nvw));
    if (e_nvw) chk(req, "nv_wr_data", int'(nv_wr_data), int'({1'b0, d[6:0]}));
    chk(req, "bus_rd_valid", int'(bus_rd_valid), int'(e_rdv));
    if (e_rdv) chk(req, "bus_rdata", int'(bus_rdata), int'(e_rd));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", "tap_code", int'(tap_code), 'h40);
    chk("R1", "recall_done", int'(recall_done), 0);
    chk("R1", "busy", int'(busy), 1);
    chk("R1", "nv_rd_req", int'(nv_rd_req), 0);
    chk("R1", "nv_wr_req", int'(nv_wr_req), 0);
    rst = 1'b0;
    n = 0;
    while (!nv_rd_req && n < 1000) begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        bus_addr = 11'h7FF; bus_wdata = 8'h11; bus_lsb_stb = 1'b1; bus_rd_req = 1'b1;
      end else if (n == 2) begin
        bus_lsb_stb = 1'b0; bus_rd_req = 1'b0;
        chk("R3", "tap_code while busy", int'(tap_code), 'h40);
        chk("R3", "bus_rd_valid while busy", int'(bus_rd_valid), 0);
        bus_addr = 11'h7FF; bus_wdata = 8'h22; bus_wr_stb = 1'b1;
      end else if (n == 3) begin
        bus_wr_stb = 1'b0;
        chk("R3", "nv_wr_req while busy", int'(nv_wr_req), 0);
      end
    end
    chk("R2", "edges to nv_rd_req", n, W);
    @(negedge clk);
    chk("R2", "nv_rd_req one cycle", int'(nv_rd_req), 0);
    nv_rd_data = 8'hA5; nv_rd_valid = 1'b1;
    @(negedge clk);
    nv_rd_valid = 1'b0;
    chk("R2", "tap after recall", int'(tap_code), 'h25);
    chk("R2", "recall_done", int'(recall_done), 1);
    chk("R2", "busy cleared", int'(busy), 0);
    m_tap = 7'h25; m_copy = 7'h25; m_mode = 1'b0;

    bus_op(2, 11'h7FF, 8'h00, "R7");
    bus_op(2, 11'h7FE, 8'h00, "R8");
    bus_op(0, 11'h7FF, 8'hFF, "R4");
    bus_op(1, 11'h7FE, 8'h81, "R5");
    bus_op(2, 11'h7FE, 8'h00, "R5");
    bus_op(1, 11'h7FE, 8'h80, "R10");
    bus_op(1, 11'h7FF, 8'h33, "R10");
    bus_op(0, 11'h7FF, 8'h33, "R10");
    bus_op(2, 11'h7FF, 8'h00, "R7");
    bus_op(1, 11'h7FE, 8'h00, "R10");
    bus_op(1, 11'h7FF, 8'h44, "R6");
    bus_op(2, 11'h7FF, 8'h00, "R7");
    bus_op(1, 11'h7FC, 8'h80, "R9");
    bus_op(0, 11'h7FD, 8'h12, "R9");
    bus_op(2, 11'h7FC, 8'h00, "R9");
    bus_op(2, 11'h7FE, 8'h00, "R9");

    for (int i = 0; i < 400; i++) begin
      logic [10:0] a;
      logic [7:0]  d;
      int          k;
      case ($urandom_range(0, 4))
        0: a = 11'h7FF;
        1: a = 11'h7FE;
        2: a = 11'h7FC;
        3: a = 11'h7FD;
        default: a = 11'($urandom_range(0, 2043));
      endcase
      d = 8'($urandom);
      if (a == 11'h7FE && $urandom_range(0, 1) == 0) d = {d[7], 7'd0};
      k = $urandom_range(0, 2);
      if (a == 11'h7FF) bus_op(k, a, d, (k == 0) ? "R4" : (k == 1) ? "R6" : "R7");
      else if (a == 11'h7FE) bus_op(k, a, d, (k == 2) ? "R8" : "R5");
      else bus_op(k, a, d, "R9");
    end
    summary();
  end
endmodule